// File: doc/BRIEF.md
# Linked-List Memory-to-Memory DMA Channel

This block is one DMA channel that copies data from memory to memory by following a chain of descriptors. While the channel is stopped, software loads four channel registers: a source address, a destination address, a link pointer and a control word. A one-cycle start pulse then sets the channel running. The engine owns a single bus master port that uses a request/grant handshake. For each item it performs one read from the source and then one write of the returned data to the destination, and it counts the remaining items down to zero.

When the count is exhausted the channel raises a terminal-count pulse, unless the control word masks it. If the link pointer is nonzero, the engine fetches a new four-word descriptor from memory, replaces all four channel registers with it and carries on. If the link pointer is zero, the channel stops. A bus error on any access stops the channel at once and raises an error pulse. The `chan_en` output stays high exactly while the channel is running, so software can poll it to learn that the chain has finished.

Top module: `llchan_dma`

## Requirements
- R1: While `chan_en` is low, a `cfg_we` write loads the register chosen by `cfg_sel`: 0 for source, 1 for destination, 2 for link pointer, 3 for control word. The link pointer's two lowest bits are stored as zero. A `cfg_go` pulse while `chan_en` is low sets `chan_en` high on the next clock edge.
- R2: The bus is used only while `chan_en` is high. An access completes only in a cycle where `bus_req`, `bus_gnt` and `bus_ack` are all high. While the grant is withheld, `bus_req`, `bus_addr` and `bus_we` hold steady and no data moves. Each item is a read (`bus_we`=0) at the source address, followed by a write (`bus_we`=1) at the destination address that carries the data just read.
- R3: The control word fields are: count in bits [11:0], width in bits [13:12], source increment in bit 14, destination increment in bit 15, terminal-count enable in bit 16. Widths 0, 1 and 2 step the address by 1, 2 and 4. An address advances after each item only when its increment bit is set. `bus_size` equals the width field during item accesses and equals 2 during descriptor fetches.
- R4: The count drops by one after each completed item write. A descriptor whose count is 0 moves no items.
- R5: When the count is zero, `tc_irq` pulses for one cycle if bit 16 is set. For a descriptor that moved items, the pulse comes two cycles after the cycle in which the final write completes. Nothing pulses if bit 16 is clear.
- R6: If the link pointer is nonzero at terminal count, the engine reads four words at link, link+4, link+8 and link+12, in that order. They go into source, destination, link pointer and control respectively, and transfers then resume under the new descriptor.
- R7: If the link pointer is zero at terminal count, `chan_en` falls on the same clock edge that raises `tc_irq`.
- R8: A bus error (`bus_err` high with `bus_req` and `bus_gnt`) during an item access or a descriptor fetch causes a one-cycle `err_irq` pulse, drops `chan_en` on that same edge, and stops all further requests. The aborted access writes nothing.
- R9: While `chan_en` is high, `cfg_we` and `cfg_go` have no effect on the running chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe, honoured while stopped |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 link, 3 control |
| cfg_wdata | input | 32 | Register write value |
| cfg_go | input | 1 | Start pulse |
| chan_en | output | 1 | High while the channel is running |
| tc_irq | output | 1 | One-cycle terminal-count pulse |
| err_irq | output | 1 | One-cycle bus-error pulse |
| bus_req | output | 1 | Bus access request |
| bus_gnt | input | 1 | Bus grant |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_size | output | 2 | Access width code (0 byte, 1 half, 2 word) |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |

## Verification
The bench builds the block with its default 32-bit address and 12-bit count. It attaches a small memory model in which any address with bit 15 set answers with an error, and a pseudo-random grant that stalls roughly one cycle in four. With counts kept to 1 through 4, the bench can sweep every width and every combination of increment flags, and it compares the whole memory against an arithmetic model after each run, so stray writes and non-incrementing addresses are caught. Separate runs cover a three-descriptor chain with a misaligned link, a zero count, errors during item and fetch accesses, a withheld grant, and configuration traffic while the chain is running.

// File: rtl/llchan_pkg.sv
package llchan_pkg;

    localparam int CNT_W  = 12;
    localparam int WORD_W = 32;

    // Control word layout (low to high): count, width, src inc, dst inc, tc enable
    typedef struct packed {
        logic [14:0]      rsvd;
        logic             tc_en;
        logic             dst_inc;
        logic             src_inc;
        logic [1:0]       width;
        logic [CNT_W-1:0] count;
    } ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_FETCH
    } state_t;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_LINK = 2'd2,
        SEL_CTL  = 2'd3
    } sel_t;

    function automatic logic [2:0] step_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/llchan_regs.sv
module llchan_regs
    import llchan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              advance,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [ADDR_W-1:0] link_q,
    output ctl_t              ctl_q
);

    logic [ADDR_W-1:0] step;
    assign step = ADDR_W'(step_bytes(ctl_q.width));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            link_q <= '0;
            ctl_q  <= '0;
        end else if (wr_en) begin
            case (sel_t'(wr_sel))
                SEL_SRC:  src_q  <= ADDR_W'(wr_data);
                SEL_DST:  dst_q  <= ADDR_W'(wr_data);
                SEL_LINK: link_q <= {ADDR_W'(wr_data) >> 2, 2'b00} [ADDR_W-1:0];
                default:  ctl_q  <= ctl_t'(wr_data);
            endcase
        end else if (advance) begin
            if (ctl_q.src_inc) src_q <= src_q + step;
            if (ctl_q.dst_inc) dst_q <= dst_q + step;
            ctl_q.count <= ctl_q.count - 1'b1;
        end
    end

    // R4
    no_adv_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        advance |-> ctl_q.count != '0);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !wr_en) |=> ctl_q.count == $past(ctl_q.count) - 1'b1);

    // R1
    link_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == 2'd2 |=> link_q[1:0] == 2'b00);

endmodule

// File: rtl/llchan_fsm.sv
module llchan_fsm
    import llchan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] src_q,
    input  logic [ADDR_W-1:0] dst_q,
    input  logic [ADDR_W-1:0] link_q,
    input  ctl_t              ctl_q,
    output logic              running,
    output logic              tc_pulse,
    output logic              err_pulse,
    output logic              advance,
    output logic              ld_en,
    output logic [1:0]        ld_sel,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    state_t            st;
    logic [1:0]        widx;
    logic [ADDR_W-1:0] fptr;
    logic [WORD_W-1:0] hold;
    logic              done, fault, cnt_zero;

    assign bus_req  = (st == ST_READ) || (st == ST_WRITE) || (st == ST_FETCH);
    assign done     = bus_req && bus_gnt && bus_ack;
    assign fault    = bus_req && bus_gnt && bus_err;
    assign cnt_zero = (ctl_q.count == '0);
    assign running  = (st != ST_IDLE);

    always_comb begin
        bus_we    = (st == ST_WRITE);
        bus_wdata = hold;
        case (st)
            ST_READ:  begin bus_addr = src_q; bus_size = ctl_q.width; end
            ST_WRITE: begin bus_addr = dst_q; bus_size = ctl_q.width; end
            default:  begin bus_addr = fptr + ADDR_W'({widx, 2'b00}); bus_size = 2'd2; end
        endcase
    end

    assign advance = (st == ST_WRITE) && done && !fault;
    assign ld_en   = (st == ST_FETCH) && done && !fault;
    assign ld_sel  = widx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            widx      <= '0;
            fptr      <= '0;
            hold      <= '0;
            tc_pulse  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            tc_pulse  <= 1'b0;
            err_pulse <= 1'b0;
            if (fault) begin
                err_pulse <= 1'b1;
                st        <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (go) st <= ST_CHECK;
                    ST_CHECK: begin
                        if (cnt_zero) begin
                            tc_pulse <= ctl_q.tc_en;
                            if (link_q != '0) begin
                                st   <= ST_FETCH;
                                widx <= '0;
                                fptr <= link_q;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            st <= ST_READ;
                        end
                    end
                    ST_READ: if (done) begin
                        hold <= bus_rdata;
                        st   <= ST_WRITE;
                    end
                    ST_WRITE: if (done) st <= ST_CHECK;
                    ST_FETCH: if (done) begin
                        if (widx == 2'd3) st <= ST_CHECK;
                        widx <= widx + 1'b1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !(bus_gnt && (bus_ack || bus_err)))
            |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R2
    wdata_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_gnt && bus_ack && st == ST_READ)
            |=> bus_we && bus_wdata == $past(bus_rdata));

    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && bus_err) |=> err_pulse && !running && !bus_req);

    // R7
    tc_last_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && !running) |-> $past(link_q) == '0);

    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tc_pulse, err_pulse}));

endmodule

// File: rtl/llchan_dma.sv
module llchan_dma
    import llchan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_go,
    output logic              chan_en,
    output logic              tc_irq,
    output logic              err_irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    logic [ADDR_W-1:0] src_q, dst_q, link_q;
    ctl_t              ctl_q;
    logic              advance, ld_en, wr_en;
    logic [1:0]        ld_sel, wr_sel;
    logic [WORD_W-1:0] wr_data;

    assign wr_en   = ld_en || (cfg_we && !chan_en);
    assign wr_sel  = ld_en ? ld_sel : cfg_sel;
    assign wr_data = ld_en ? bus_rdata : cfg_wdata;

    llchan_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .advance (advance),
        .src_q   (src_q),
        .dst_q   (dst_q),
        .link_q  (link_q),
        .ctl_q   (ctl_q)
    );

    llchan_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (cfg_go),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .link_q    (link_q),
        .ctl_q     (ctl_q),
        .running   (chan_en),
        .tc_pulse  (tc_irq),
        .err_pulse (err_irq),
        .advance   (advance),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err)
    );

    // R9
    cfg_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && cfg_we && !ld_en) |=> $stable(ctl_q) && $stable(link_q));

endmodule

// File: tb/tb_llchan_dma.sv
module tb_llchan_dma;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_go;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        chan_en, tc_irq, err_irq;
    logic        bus_req, bus_gnt, bus_we, bus_ack, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;

    always #2.5 clk = ~clk;

    llchan_dma dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_go(cfg_go), .chan_en(chan_en), .tc_irq(tc_irq), .err_irq(err_irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    // memory model: index by low 10 address bits, error when bit 15 set
    logic [31:0] mem [0:1023];
    logic [31:0] expm [0:1023];
    logic        bad_addr;
    assign bad_addr  = bus_addr[15];
    assign bus_ack   = bus_req && bus_gnt && !bad_addr;
    assign bus_err   = bus_req && bus_gnt && bad_addr;
    assign bus_rdata = mem[bus_addr[9:0]];

    always @(posedge clk)
        if (bus_req && bus_gnt && !bad_addr && bus_we) mem[bus_addr[9:0]] <= bus_wdata;

    int         gmode = 0;  // 0 always, 1 pseudo-random, 2 never
    logic [7:0] lfsr = 8'h5D;
    always @(posedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bus_gnt <= (gmode == 0) ? 1'b1 : (gmode == 2) ? 1'b0 : (lfsr[0] | lfsr[3]);
    end

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctlw(input int cnt, input int w, input bit si,
                                         input bit di, input bit ie);
        return (32'(ie) << 16) | (32'(di) << 15) | (32'(si) << 14) | (32'(w) << 12) | 32'(cnt);
    endfunction

    task automatic mem_init();
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 32'h5A00_0000 + i * 3;
            expm[i] = 32'h5A00_0000 + i * 3;
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        mem[a]  = v;
        expm[a] = v;
    endtask

    task automatic model_copy(input int s, input int d, input int cnt, input int w,
                              input bit si, input bit di);
        int step = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        for (int k = 0; k < cnt; k++)
            expm[(d + (di ? k * step : 0)) & 1023] = expm[(s + (si ? k * step : 0)) & 1023];
    endtask

    task automatic cfg_write(input int sel, input logic [31:0] v);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_start(input logic [31:0] s, input logic [31:0] d,
                              input logic [31:0] l, input logic [31:0] c);
        cfg_write(0, s); cfg_write(1, d); cfg_write(2, l); cfg_write(3, c);
        cfg_go = 1'b1;
        @(negedge clk);
        cfg_go = 1'b0;
    endtask

    int tcs, errs, size_bad, last_wr, tc_at;
    task automatic wait_done(input int exp_size);
        int n = 0;
        tcs = 0; errs = 0; size_bad = 0; last_wr = -1; tc_at = -1;
        while (chan_en && n < 4000) begin
            if (bus_req && bus_addr < 32'h300 && exp_size >= 0 && bus_size != 2'(exp_size))
                size_bad++;
            if (bus_req && bus_gnt && bus_ack && bus_we) last_wr = cyc;
            if (tc_irq) begin tcs++; tc_at = cyc; end
            if (err_irq) errs++;
            @(negedge clk);
            n++;
        end
        repeat (3) begin
            if (tc_irq) begin tcs++; tc_at = cyc; end
            if (err_irq) errs++;
            @(negedge clk);
        end
        if (n >= 4000) chk(1'b0, "watchdog wait", n, 0);
    endtask

    function automatic int mem_diff();
        int bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) bad++;
        return bad;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_go = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        mem_init();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!chan_en && !bus_req && !tc_irq && !err_irq, "R1 reset state",
            {chan_en, bus_req, tc_irq, err_irq}, 0);

        // Sweep: width x increment flags x count (R2 R3 R4 R5 R7)
        gmode = 1;
        for (int w = 0; w < 3; w++)
            for (int fl = 0; fl < 4; fl++)
                for (int n = 1; n <= 4; n++) begin
                    bit ie = n[0];
                    mem_init();
                    model_copy(32'h100, 32'h200, n, w, fl[0], fl[1]);
                    load_start(32'h100, 32'h200, 32'h0, ctlw(n, w, fl[0], fl[1], ie));
                    wait_done(w);
                    chk(mem_diff() == 0, "R2 R3 R4 sweep memory", mem_diff(), 0);
                    chk(size_bad == 0, "R3 bus_size", size_bad, 0);
                    chk(tcs == int'(ie) && errs == 0, "R5 R7 tc count", tcs, int'(ie));
                    chk(!chan_en, "R7 stopped", chan_en, 0);
                end

        // R5 tc timing after final write
        gmode = 0;
        mem_init();
        model_copy(32'h100, 32'h200, 3, 2, 1, 1);
        load_start(32'h100, 32'h200, 32'h0, ctlw(3, 2, 1, 1, 1));
        wait_done(2);
        chk(tc_at - last_wr == 2, "R5 tc two cycles after final write", tc_at - last_wr, 2);

        // R4 zero count: no items, tc still pulses
        mem_init();
        load_start(32'h100, 32'h200, 32'h0, ctlw(0, 2, 1, 1, 1));
        wait_done(-1);
        chk(mem_diff() == 0, "R4 zero count no writes", mem_diff(), 0);
        chk(tcs == 1, "R4 zero count tc", tcs, 1);

        // R6 chain of three, misaligned initial link, third tc masked
        gmode = 1;
        mem_init();
        put_word(32'h300, 32'h140); put_word(32'h304, 32'h240);
        put_word(32'h308, 32'h310); put_word(32'h30C, ctlw(3, 2, 1, 1, 1));
        put_word(32'h310, 32'h180); put_word(32'h314, 32'h280);
        put_word(32'h318, 32'h0);   put_word(32'h31C, ctlw(2, 1, 1, 0, 0));
        model_copy(32'h100, 32'h200, 2, 2, 1, 1);
        model_copy(32'h140, 32'h240, 3, 2, 1, 1);
        model_copy(32'h180, 32'h280, 2, 1, 1, 0);
        load_start(32'h100, 32'h200, 32'h301, ctlw(2, 2, 1, 1, 1));
        wait_done(-1);
        chk(mem_diff() == 0, "R6 chain memory", mem_diff(), 0);
        chk(tcs == 2, "R6 chain tc pulses", tcs, 2);
        chk(errs == 0 && !chan_en, "R6 chain end", errs, 0);

        // R8 error on source read
        mem_init();
        load_start(32'h8100, 32'h200, 32'h0, ctlw(3, 2, 1, 1, 1));
        wait_done(-1);
        chk(errs == 1 && tcs == 0, "R8 item error pulses", {errs, tcs}, 1);
        chk(mem_diff() == 0 && !chan_en, "R8 item error no writes", mem_diff(), 0);

        // R8 error during descriptor fetch
        mem_init();
        model_copy(32'h100, 32'h200, 2, 2, 1, 1);
        load_start(32'h100, 32'h200, 32'h8000, ctlw(2, 2, 1, 1, 1));
        wait_done(-1);
        chk(errs == 1 && tcs == 1, "R8 fetch error pulses", {errs, tcs}, 32'h0001_0001);
        chk(mem_diff() == 0 && !chan_en, "R8 fetch error stops", mem_diff(), 0);

        // R2 grant withheld: nothing moves
        gmode = 2;
        mem_init();
        model_copy(32'h100, 32'h200, 2, 2, 1, 1);
        load_start(32'h100, 32'h200, 32'h0, ctlw(2, 2, 1, 1, 1));
        repeat (20) @(negedge clk);
        chk(chan_en && bus_req && !bus_we && bus_addr == 32'h100, "R2 stall holds request",
            bus_addr, 32'h100);
        chk(mem[32'h200] == 32'h5A00_0000 + 32'h200 * 3, "R2 no data without grant",
            mem[32'h200], 32'h5A00_0000 + 32'h200 * 3);
        gmode = 0;
        wait_done(2);
        chk(mem_diff() == 0, "R2 after grant", mem_diff(), 0);

        // R9 config traffic while running is ignored
        gmode = 1;
        mem_init();
        model_copy(32'h100, 32'h200, 6, 2, 1, 1);
        load_start(32'h100, 32'h200, 32'h0, ctlw(6, 2, 1, 1, 1));
        cfg_write(1, 32'h3F0);
        cfg_write(3, ctlw(1, 0, 0, 0, 0));
        cfg_go = 1'b1; @(negedge clk); cfg_go = 1'b0;
        wait_done(2);
        chk(mem_diff() == 0, "R9 writes while running ignored", mem_diff(), 0);
        chk(tcs == 1, "R9 tc unaffected", tcs, 1);
        repeat (5) @(negedge clk);
        chk(!chan_en, "R9 go while running did not restart", chan_en, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule